// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block holds the thirty-two 16-bit management registers that a copper Ethernet PHY exposes to its station manager. Accesses come in over a plain parallel port: a register index, a write strobe, write data, and a read-data output. The serial frame decoder that turns management frames into these accesses lives outside the block.

Each register carries a fixed protection mask. A write changes only the unprotected bits; protected bits keep what they held. The mask is what keeps the two self-clearing command bits of the control register from reading back as set. It also keeps the identifier words and the link-partner ability word unchanged by software writes. The identifier words are build-time parameters and are loaded by reset.

Top module: `phy_mgmt_regs`

## Requirements
- R1: `addr` selects one of 32 registers (index 0 to 31), and `rd_data` shows the selected register combinationally in the same cycle.
- R2: A register changes only on a rising `clk` edge with `wr_en` high and `addr` equal to its index. With `wr_en` low, all contents stay unchanged whatever `wr_data` holds.
- R3: On a write, every bit whose mask bit is 1 keeps its old value, and every bit whose mask bit is 0 takes `wr_data`. Registers 1, 4 and 6 through 31 have an all-zero mask, so they store `wr_data` unchanged.
- R4: Control register 0 has mask 0x8200. Bit 15 (PHY reset command) and bit 9 (restart autonegotiation command) never read back as 1 after a write. Its other 14 bits store `wr_data`.
- R5: Identifier registers 2 and 3 have mask 0xFFFF. They always read back parameters `ID_HI` and `ID_LO` after reset, whatever is written to them.
- R6: Link-partner ability register 5 has mask 0xFFFF and reads 0x0000 after reset, whatever is written to it.
- R7: With `rst` high at a rising edge, the registers load their reset values: register 0 = 0x3100, register 2 = `ID_HI`, register 3 = `ID_LO`, register 4 = 0x01E1, and all others 0x0000.
- R8: Reset is synchronous and active high, and it takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Register index for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Data to merge into the addressed register |
| rd_data | output | 16 | Contents of the addressed register |

## Verification
The bench builds the block with `ID_HI` = 0x0141 and `ID_LO` = 0x0CC2. These differ from the defaults and from each other, so a swapped, missing or stuck identifier reload is visible at `rd_data`. With these values, writes of both all-ones and all-zeros to the identifier words show that the words hold a value that no write pattern could produce. The full sweep over all 32 indices reaches the upper registers. A fault in the highest index bit would therefore alias onto registers that have different masks.

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs #(
  parameter logic [15:0] ID_HI  = 16'h0022,
  parameter logic [15:0] ID_LO  = 16'h1610,
  parameter int          ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data
);

  localparam int NREG = 1 << ADDR_W;

  localparam int IDX_CTRL = 0;
  localparam int IDX_IDH  = 2;
  localparam int IDX_IDL  = 3;
  localparam int IDX_ADV  = 4;
  localparam int IDX_LPA  = 5;

  localparam logic [15:0] CMD_BITS = 16'h8200;

  function automatic logic [15:0] keep_mask(int idx);
    case (idx)
      IDX_CTRL:                  keep_mask = CMD_BITS;
      IDX_IDH, IDX_IDL, IDX_LPA: keep_mask = 16'hFFFF;
      default:                   keep_mask = 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] init_val(int idx);
    case (idx)
      IDX_CTRL: init_val = 16'h3100;
      IDX_IDH:  init_val = ID_HI;
      IDX_IDL:  init_val = ID_LO;
      IDX_ADV:  init_val = 16'h01E1;
      default:  init_val = 16'h0000;
    endcase
  endfunction

  logic [15:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [15:0] MASK = keep_mask(i);
    localparam logic [15:0] INIT = init_val(i);
    wire hit = wr_en && (addr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= INIT;
      else if (hit)
        regs[i] <= (regs[i] & MASK) | (wr_data & ~MASK);
    end
  end

  assign rd_data = regs[addr];

  assert_ctrl_cmd_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(IDX_CTRL)) |=> (regs[IDX_CTRL][15] == 1'b0 && regs[IDX_CTRL][9] == 1'b0));

  assert_ctrl_rw_bits_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(IDX_CTRL)) |=> ((regs[IDX_CTRL] & ~CMD_BITS) == ($past(wr_data) & ~CMD_BITS)));

  assert_adv_store_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(IDX_ADV)) |=> (regs[IDX_ADV] == $past(wr_data)));

  assert_id_hold_R5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) || $past(wr_en) |-> (regs[IDX_IDH] == ID_HI && regs[IDX_IDL] == ID_LO));

  assert_lpa_hold_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) || $past(wr_en) |-> (regs[IDX_LPA] == 16'h0000));

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(regs[IDX_CTRL]) && $stable(regs[IDX_ADV]) && $stable(regs[NREG-1])));

  assert_reset_load_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (regs[IDX_CTRL] == 16'h3100 && regs[IDX_ADV] == 16'h01E1));

endmodule

// File: tb/tb_phy_mgmt_regs.sv
module tb_phy_mgmt_regs;

  localparam logic [15:0] T_ID_HI = 16'h0141;
  localparam logic [15:0] T_ID_LO = 16'h0CC2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  phy_mgmt_regs #(.ID_HI(T_ID_HI), .ID_LO(T_ID_LO), .ADDR_W(5)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  // {addr, write data, expected read-back}
  localparam logic [36:0] VEC [8] = '{
    {5'd0,  16'hFFFF, 16'h7DFF},
    {5'd0,  16'h0000, 16'h0000},
    {5'd2,  16'hFFFF, 16'h0141},
    {5'd4,  16'h1234, 16'h1234},
    {5'd5,  16'hABCD, 16'h0000},
    {5'd1,  16'h5A5A, 16'h5A5A},
    {5'd31, 16'hFFFF, 16'hFFFF},
    {5'd3,  16'h0000, 16'h0CC2}
  };

  function automatic logic [15:0] m_mask(int i);
    if (i == 0) return 16'h8200;
    if (i == 2 || i == 3 || i == 5) return 16'hFFFF;
    return 16'h0000;
  endfunction

  function automatic logic [15:0] m_init(int i);
    case (i)
      0: return 16'h3100;
      2: return T_ID_HI;
      3: return T_ID_LO;
      4: return 16'h01E1;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(logic [4:0] a, output logic [15:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [15:0] mdl [32];

    repeat (2) @(negedge clk);
    rst = 1'b0;

    // R7: reset values of every register
    for (int i = 0; i < 32; i++) begin
      do_read(5'(i), v);
      check($sformatf("R7 reset reg %0d", i), v, m_init(i));
    end

    // R3 R4 R5 R6 R1: vector table
    for (int k = 0; k < 8; k++) begin
      do_write(VEC[k][36:32], VEC[k][31:16]);
      do_read(VEC[k][36:32], v);
      check($sformatf("R3/R4/R5/R6 vector %0d", k), v, VEC[k][15:0]);
    end

    // R2: data on the bus with the strobe low changes nothing
    @(negedge clk);
    addr = 5'd4; wr_data = 16'hFFFF; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    do_read(5'd4, v);
    check("R2 idle write reg 4", v, 16'h1234);
    do_read(5'd31, v);
    check("R2 idle reg 31", v, 16'hFFFF);

    // R1: combinational read follows addr within the cycle
    @(negedge clk);
    do_read(5'd1, v);
    check("R1 read reg 1", v, 16'h5A5A);
    do_read(5'd2, v);
    check("R1 read reg 2 same cycle", v, T_ID_HI);

    // R3 R4 R5 R6: all-ones then all-zeros into every register, reference model
    pulse_reset();
    for (int i = 0; i < 32; i++) mdl[i] = m_init(i);
    for (int i = 0; i < 32; i++) begin
      mdl[i] = (mdl[i] & m_mask(i)) | (16'hFFFF & ~m_mask(i));
      do_write(5'(i), 16'hFFFF);
      do_read(5'(i), v);
      check($sformatf("R3 ones reg %0d", i), v, mdl[i]);
      mdl[i] = (mdl[i] & m_mask(i)) | (16'h0000 & ~m_mask(i));
      do_write(5'(i), 16'h0000);
      do_read(5'(i), v);
      check($sformatf("R3 zeros reg %0d", i), v, mdl[i]);
    end
    do_read(5'd0, v);
    check("R4 ctrl command bits clear", v & 16'h8200, 16'h0000);

    // R8: reset wins over a simultaneous write
    do_write(5'd0, 16'h1000);
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; addr = 5'd4; wr_data = 16'hFFFF;
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
    do_read(5'd4, v);
    check("R8 reset over write reg 4", v, 16'h01E1);
    do_read(5'd0, v);
    check("R8 reset restores reg 0", v, 16'h3100);

    finish_run();
  end

endmodule